// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Wake

This block keeps wall-clock time for a power-management controller. A slow oscillator enable (nominally 32 kHz) is divided down to a one-second tick. The tick advances an 8-bit seconds count and a 24-bit minutes count. Software reaches the time, the alarm and the control bits through a small byte-wide register port: a write strobe with an address and data, and a separate read address with a combinational read-data output.

Two events come out of the counter. The alarm event fires once when the running time equals a programmed alarm value. The alarm is loaded byte by byte into a staging area and becomes active only when its top minute byte is written. The periodic event fires every second, every minute, every second minute or every eighth minute, as selected by a 2-bit mode field. Each event gives a one-cycle interrupt pulse and sets a sticky status flag. While the system reports that it is powered off, each event can also raise a wake request if that event's wake enable is set.

Top module: `rtc_wake_timer`

## Requirements
- R1: After reset the seconds and all three minute bytes read 00h, the alarm seconds byte reads 3Fh, the three alarm minute bytes read FFh, the control register (address 0) and the status register (address 9) read 00h, and no interrupt or wake output is active.
- R2: The control register sits at address 0. Bit 0 is the run enable. While it is set, the seconds count advances by exactly one for every 2^DIV_BITS cycles in which osc_tick is high. While it is clear, the time holds its value.
- R3: Seconds are at address 1 and the minute bytes are at addresses 2, 3 and 4, least significant first. When the seconds count steps past 59 it becomes 0, and in the same update the 24-bit minutes value gains one, carrying across bytes and wrapping from FFFFFFh to 000000h.
- R4: The alarm seconds byte is at address 5 and the alarm minute bytes are at addresses 6, 7 and 8. Writes to addresses 5 to 7 are only staged. The write to address 8 makes the whole staged alarm active. Reads of addresses 5 to 8 return the active alarm, and a staged value that has not been committed never triggers the alarm.
- R5: alarm_irq pulses high for exactly one cycle when the time first equals the active alarm, and it pulses only once while the time keeps that value.
- R6: Control bits 4:3 select the periodic mode. With mode 0, repeat_irq pulses once for every second step.
- R7: With mode 1, repeat_irq pulses once for each seconds wrap, which is once per minute.
- R8: With mode 2, repeat_irq pulses only on a seconds wrap that leaves the minutes value even.
- R9: With mode 3, repeat_irq pulses only on a seconds wrap that leaves the minutes value a multiple of 8.
- R10: Each pulse sets a sticky status bit: bit 0 for alarm, bit 1 for the periodic event. Writing a 1 to a bit at address 9 clears that bit.
- R11: wake_req is high in a cycle only when powered_off is high and either alarm_irq is high with control bit 1 set, or repeat_irq is high with control bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per slow oscillator period |
| powered_off | input | 1 | High while the system is in its off state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| alarm_irq | output | 1 | One-cycle alarm event pulse |
| repeat_irq | output | 1 | One-cycle periodic event pulse |
| wake_req | output | 1 | Wake request while powered off |

## Verification
The counter is started from chosen times: mid-minute, second 59 with a minute byte at FFh, and the all-ones minute value. These starts separate a plain seconds step from a byte carry and from a full 24-bit wrap. The periodic modes are each run across a wrap into an even minute and into an odd minute, and into a multiple of eight and into a value that is not. This shows that the parity and modulo tests are applied to the new minute value and not the old one. The alarm is tried once with a committed value and once with only its seconds byte staged. That pair tells a correct commit-on-top-byte apart from a design that compares staged bytes.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
    localparam int SEC_W     = 8;
    localparam int MIN_W     = 24;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int MIN_BYTES = MIN_W / DATA_W;

    localparam logic [SEC_W-1:0] SEC_LAST = 8'd59;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC      = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN0     = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALM_SEC  = 4'd5;
    localparam logic [ADDR_W-1:0] A_ALM_MIN0 = 4'd6;
    localparam logic [ADDR_W-1:0] A_ALM_TOP  = A_ALM_MIN0 + ADDR_W'(MIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'd9;

    localparam logic [SEC_W-1:0] ALM_SEC_RST = 8'h3F;

    typedef enum logic [1:0] {
        REP_SEC  = 2'd0,
        REP_MIN  = 2'd1,
        REP_2MIN = 2'd2,
        REP_8MIN = 2'd3
    } rep_mode_e;

    typedef struct packed {
        logic [MIN_W-1:0] mins;
        logic [SEC_W-1:0] secs;
    } rtc_time_t;

    // bit order matches the control byte: [4:3] mode, [2] repeat wake, [1] alarm wake, [0] run
    typedef struct packed {
        rep_mode_e mode;
        logic      rep_wake_en;
        logic      alm_wake_en;
        logic      run;
    } rtc_ctrl_t;

    // decides on a second step whether the periodic event is due;
    // min_lsbs are the low bits of the minutes value before the step
    function automatic logic rep_due(rep_mode_e mode, logic at_last, logic [2:0] min_lsbs);
        logic due;
        unique case (mode)
            REP_SEC:  due = 1'b1;
            REP_MIN:  due = at_last;
            REP_2MIN: due = at_last && min_lsbs[0];
            REP_8MIN: due = at_last && (min_lsbs == 3'd7);
            default:  due = 1'b0;
        endcase
        return due;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_tick,
    output logic sec_tick
);
    logic [DIV_BITS-1:0] cnt;

    assign sec_tick = run && osc_tick && (&cnt);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (osc_tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rtc_time_t         now
);
    rtc_time_t nxt;
    logic      wr_hit;

    assign wr_hit = wr_en && (wr_addr >= A_SEC) && (wr_addr < A_MIN0 + ADDR_W'(MIN_BYTES));

    always_comb begin
        nxt = now;
        if (sec_tick) begin
            if (now.secs >= SEC_LAST) begin
                nxt.secs = '0;
                nxt.mins = now.mins + 1'b1;
            end else begin
                nxt.secs = now.secs + 1'b1;
            end
        end
        if (wr_en && wr_addr == A_SEC) nxt.secs = wr_data;
        for (int i = 0; i < MIN_BYTES; i++) begin
            if (wr_en && wr_addr == A_MIN0 + ADDR_W'(i)) nxt.mins[DATA_W*i +: DATA_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= nxt;
    end

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_hit && now.secs == SEC_LAST)
        |=> (now.secs == '0 && now.mins == MIN_W'($past(now.mins) + 1)));

    // R2
    time_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !wr_hit) |=> $stable(now));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  rtc_time_t         now,
    output rtc_time_t         active,
    output logic              alarm_irq
);
    localparam int STG_W = MIN_W - DATA_W;

    logic [SEC_W-1:0] stg_sec;
    logic [STG_W-1:0] stg_min;
    logic             match, match_q, commit;

    assign commit = wr_en && (wr_addr == A_ALM_TOP);
    assign match  = (now == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_sec   <= ALM_SEC_RST;
            stg_min   <= '1;
            active    <= '{mins: '1, secs: ALM_SEC_RST};
            match_q   <= 1'b0;
            alarm_irq <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_ALM_SEC) stg_sec <= wr_data;
            for (int i = 0; i < MIN_BYTES - 1; i++) begin
                if (wr_en && wr_addr == A_ALM_MIN0 + ADDR_W'(i)) stg_min[DATA_W*i +: DATA_W] <= wr_data;
            end
            if (commit) active <= '{mins: {wr_data, stg_min}, secs: stg_sec};
            match_q   <= match;
            alarm_irq <= match && !match_q;
        end
    end

    // R5
    alarm_once_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |=> !alarm_irq);

    // R4
    alarm_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= A_ALM_SEC && wr_addr < A_ALM_TOP) |=> $stable(active));
endmodule

// File: rtl/rtc_repeat_unit.sv
module rtc_repeat_unit
    import rtc_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_tick,
    input  rep_mode_e mode,
    input  logic      at_last,
    input  logic [2:0] min_lsbs,
    output logic      repeat_irq
);
    always_ff @(posedge clk) begin
        if (rst) repeat_irq <= 1'b0;
        else     repeat_irq <= sec_tick && rep_due(mode, at_last, min_lsbs);
    end

    // R6
    repeat_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        repeat_irq |-> $past(sec_tick));
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer
    import rtc_wake_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        powered_off,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        alarm_irq,
    output logic        repeat_irq,
    output logic        wake_req
);
    rtc_ctrl_t  ctrl;
    rtc_time_t  now, alarm_active;
    logic [1:0] status;
    logic       sec_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            status <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl <= rtc_ctrl_t'(wr_data[4:0]);
            for (int b = 0; b < 2; b++) begin
                if (b == 0 ? alarm_irq : repeat_irq)               status[b] <= 1'b1;
                else if (wr_en && wr_addr == A_STATUS && wr_data[b]) status[b] <= 1'b0;
            end
        end
    end

    rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl.run), .osc_tick(osc_tick), .sec_tick(sec_tick)
    );

    rtc_time_counter u_time (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .now(now)
    );

    rtc_alarm_unit u_alarm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .now(now), .active(alarm_active), .alarm_irq(alarm_irq)
    );

    rtc_repeat_unit u_rep (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode(ctrl.mode),
        .at_last(now.secs >= SEC_LAST), .min_lsbs(now.mins[2:0]), .repeat_irq(repeat_irq)
    );

    assign wake_req = powered_off &&
                      ((alarm_irq && ctrl.alm_wake_en) || (repeat_irq && ctrl.rep_wake_en));

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)    rd_data = {3'b000, ctrl};
        if (rd_addr == A_SEC)     rd_data = now.secs;
        if (rd_addr == A_ALM_SEC) rd_data = alarm_active.secs;
        if (rd_addr == A_STATUS)  rd_data = {6'b0, status};
        for (int i = 0; i < MIN_BYTES; i++) begin
            if (rd_addr == A_MIN0 + ADDR_W'(i))     rd_data = now.mins[DATA_W*i +: DATA_W];
            if (rd_addr == A_ALM_MIN0 + ADDR_W'(i)) rd_data = alarm_active.mins[DATA_W*i +: DATA_W];
        end
    end

    // R10
    alarm_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |=> status[0]);

    // R10
    repeat_flag_chk: assert property (@(posedge clk) disable iff (rst)
        repeat_irq |=> status[1]);

    // R11
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (powered_off && (alarm_irq || repeat_irq)));
endmodule

// File: tb/rtc_wake_timer_test.sv
`timescale 1ns/1ps
module rtc_wake_timer_test;
    localparam int DIVB = 2;
    localparam int SPS  = 1 << DIVB;   // cycles per second with osc_tick held high

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b1;
    logic powered_off = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic alarm_irq, repeat_irq, wake_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt_alm, cnt_rep, cnt_wake;

    always #2.5 clk = ~clk;

    rtc_wake_timer #(.DIV_BITS(DIVB)) uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .powered_off(powered_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm_irq(alarm_irq), .repeat_irq(repeat_irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [23:0] m);
        reg_wr(4'd1, s);
        reg_wr(4'd2, m[7:0]);
        reg_wr(4'd3, m[15:8]);
        reg_wr(4'd4, m[23:16]);
    endtask

    // start counting with ctrl value c, observe for n seconds, then stop
    task automatic run_secs(input logic [7:0] c, input int n);
        cnt_alm = 0; cnt_rep = 0; cnt_wake = 0;
        reg_wr(4'd0, c);
        for (int k = 0; k < n * SPS; k++) begin
            @(negedge clk);
            if (alarm_irq)  cnt_alm++;
            if (repeat_irq) cnt_rep++;
            if (wake_req)   cnt_wake++;
        end
        reg_wr(4'd0, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [7:0] exp_v [10] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                   8'h3F, 8'hFF, 8'hFF, 8'hFF, 8'h00};
        for (int a = 0; a < 10; a++) begin
            reg_rd(4'(a), d);
            check("R1 reset register", int'(d), int'(exp_v[a]));
        end
        check("R1 reset outputs", int'({alarm_irq, repeat_irq, wake_req}), 0);
    endtask

    task automatic t_run_hold;
        logic [7:0] d;
        repeat (10 * SPS) @(negedge clk);
        reg_rd(4'd1, d);
        check("R2 stopped counter holds", int'(d), 0);
        run_secs(8'h01, 3);
        reg_rd(4'd1, d);
        check("R2 three seconds elapsed", int'(d), 3);
    endtask

    task automatic t_carry;
        logic [7:0] d0, d1, d2, d3;
        set_time(8'd59, 24'h0000FF);
        run_secs(8'h01, 1);
        reg_rd(4'd1, d0); reg_rd(4'd2, d1); reg_rd(4'd3, d2); reg_rd(4'd4, d3);
        check("R3 wrap with byte carry", int'({d3, d2, d1, d0}), 32'h00010000);
        set_time(8'd59, 24'hFFFFFF);
        run_secs(8'h01, 1);
        reg_rd(4'd1, d0); reg_rd(4'd2, d1); reg_rd(4'd3, d2); reg_rd(4'd4, d3);
        check("R3 full minute wrap", int'({d3, d2, d1, d0}), 0);
        set_time(8'd20, 24'h000005);
        run_secs(8'h01, 2);
        reg_rd(4'd1, d0); reg_rd(4'd2, d1);
        check("R3 plain step", int'({d1, d0}), 16'h0516);
    endtask

    task automatic t_repeat;
        set_time(8'd0, 24'd0);
        run_secs(8'h01 | (8'd0 << 3), 10);
        check("R6 one pulse per second", cnt_rep, 10);
        set_time(8'd50, 24'd0);
        run_secs(8'h01 | (8'd1 << 3), 20);
        check("R7 one pulse per minute", cnt_rep, 1);
        set_time(8'd55, 24'd1);
        run_secs(8'h01 | (8'd2 << 3), 10);
        check("R8 wrap into even minute", cnt_rep, 1);
        set_time(8'd55, 24'd2);
        run_secs(8'h01 | (8'd2 << 3), 10);
        check("R8 wrap into odd minute", cnt_rep, 0);
        set_time(8'd58, 24'd7);
        run_secs(8'h01 | (8'd3 << 3), 10);
        check("R9 wrap into multiple of 8", cnt_rep, 1);
        set_time(8'd58, 24'd3);
        run_secs(8'h01 | (8'd3 << 3), 10);
        check("R9 wrap into non-multiple", cnt_rep, 0);
    endtask

    task automatic t_status;
        logic [7:0] d;
        reg_rd(4'd9, d);
        check("R10 repeat flag latched", int'(d), 2);
        reg_wr(4'd9, 8'h01);
        reg_rd(4'd9, d);
        check("R10 clearing other bit keeps flag", int'(d), 2);
        reg_wr(4'd9, 8'h02);
        reg_rd(4'd9, d);
        check("R10 flag cleared", int'(d), 0);
    endtask

    task automatic t_wake;
        set_time(8'd0, 24'd0);
        powered_off = 1'b1;
        run_secs(8'h05, 5);
        check("R11 repeat wake while off", cnt_wake, 5);
        run_secs(8'h01, 5);
        check("R11 repeat wake disabled", cnt_wake, 0);
        powered_off = 1'b0;
        run_secs(8'h05, 5);
        check("R11 no wake while powered", cnt_wake, 0);
    endtask

    task automatic t_alarm;
        logic [7:0] d;
        set_time(8'd0, 24'd3);
        reg_wr(4'd5, 8'd5);
        reg_wr(4'd6, 8'd3);
        reg_wr(4'd7, 8'd0);
        reg_rd(4'd5, d);
        check("R4 staged byte not yet active", int'(d), 8'h3F);
        reg_wr(4'd8, 8'd0);
        reg_rd(4'd5, d);
        check("R4 commit on top byte", int'(d), 5);
        reg_wr(4'd9, 8'h03);
        powered_off = 1'b1;
        run_secs(8'h03, 10);
        powered_off = 1'b0;
        check("R5 alarm fires once", cnt_alm, 1);
        check("R11 alarm wake while off", cnt_wake, 1);
        reg_rd(4'd9, d);
        check("R10 alarm flag latched", int'(d[0]), 1);
        reg_wr(4'd5, 8'd8);
        reg_rd(4'd5, d);
        check("R4 staged seconds hidden", int'(d), 5);
        set_time(8'd7, 24'd3);
        run_secs(8'h01, 10);
        check("R4 uncommitted alarm ignored", cnt_alm, 0);
        reg_wr(4'd8, 8'd0);
        set_time(8'd7, 24'd3);
        run_secs(8'h01, 10);
        check("R5 committed alarm fires", cnt_alm, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run_hold();
        t_carry();
        t_repeat();
        t_status();
        t_wake();
        t_alarm();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule